// File: doc/BRIEF.md
# Flickering Rectangle Stimulus Overlay

This block colours each pixel of a raster video stream so that a rectangle flickers at a chosen rate over a flat background. A separate raster timing generator supplies the current pixel coordinates, a video-active flag and a pulse that marks the start of each frame. A set of configuration inputs sets where the rectangle sits, how large it is, its colour, the background colour, the flicker style and the flicker rate. The block returns one 24-bit colour per pixel, two clocks after the coordinates arrive.

There are two flicker styles. In the square style the rectangle is shown in its full colour for a set number of frames and then black for the same number. In the sine style the rectangle keeps its colour but its brightness follows a sampled sine wave. A phase accumulator advances by a programmable step once per frame, and its top bits pick one entry of the sine table. The block can also replace the flat rectangle colour with the pixels of an incoming picture stream. That picture is dimmed by the same gray level, so the picture inside the frame flickers with the stimulus.

The configuration inputs are copied into shadow registers only on the start-of-frame pulse, so a frame never shows a half-updated rectangle. The flicker state also moves on only at that pulse, which makes the stimulus frequency an exact fraction of the frame rate.

Top module: `stim_rect_overlay`

## Requirements
- R1: While reset is held, the output colour is 0. Reset clears the shadow rectangle to position 0 and size 0, the background to 0, the frame counter to 0 and the phase to 0, and sets the square state to "on".
- R2: A pixel is inside the rectangle exactly when x0 <= x < x0+w and y0 <= y < y0+h. The sums are formed one bit wider than the coordinates, so a rectangle that reaches the right or bottom edge of the coordinate range does not wrap, and a width or height of 0 gives an empty rectangle.
- R3: When the video-active input is low, the output colour is 0.
- R4: An active pixel outside the rectangle gets the shadow background colour.
- R5: Square style (`cfg_sine`=0). On each start-of-frame pulse, let H be `cfg_half_frames`, with 0 treated as 1. The frame counter increments; if counter+1 >= H, the counter clears and the on/off state toggles. In the "on" state an inside pixel gets its source colour unchanged (gray 256). In the "off" state it is black (gray 0). After n pulses from reset with H held constant, the state is "on" exactly when floor(n/H) is even.
- R6: Sine style (`cfg_sine`=1). On each start-of-frame pulse the 16-bit phase becomes phase + `cfg_phase_step` (mod 65536). The gray level is table[phase[15:10]], where table[i] = round(128 + 127*sin(2*pi*i/64)). Each 8-bit channel c of the source colour becomes floor(c*gray/256).
- R7: With `cfg_pic_en`=1, the source colour of an inside pixel is `pic_rgb` for that pixel instead of the rectangle colour. The gray scaling of R5 or R6 still applies. Colours are packed red in [23:16], green in [15:8] and blue in [7:0].
- R8: A change to any configuration input has no effect on the output until the next start-of-frame pulse. On that pulse the new values take effect for every following pixel.
- R9: The output colour for the inputs sampled at one rising clock edge appears after the second rising edge that follows, so the fixed latency is two clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_start | input | 1 | One-clock pulse at the start of each frame, given during blanking |
| active | input | 1 | High while the pixel lies in the visible area |
| pix_x | input | XW (11) | Current pixel column |
| pix_y | input | YW (10) | Current pixel row |
| pic_rgb | input | 3*CW (24) | Picture pixel that belongs to the current coordinates |
| cfg_x0 | input | XW (11) | Left edge of the rectangle |
| cfg_y0 | input | YW (10) | Top edge of the rectangle |
| cfg_w | input | XW (11) | Rectangle width in pixels |
| cfg_h | input | YW (10) | Rectangle height in pixels |
| cfg_color | input | 3*CW (24) | Rectangle colour |
| cfg_bg | input | 3*CW (24) | Background colour |
| cfg_sine | input | 1 | 0 = square flicker, 1 = sine brightness |
| cfg_pic_en | input | 1 | Show the picture stream inside the rectangle |
| cfg_half_frames | input | HFW (8) | Frames per half period in square style |
| cfg_phase_step | input | PHW (16) | Phase increment per frame in sine style |
| out_rgb | output | 3*CW (24) | Output pixel colour |

## Verification
Each frame the bench sweeps a window two pixels larger than the rectangle on every side. The window is streamed at one pixel per clock, and some pixels are blanked on a fixed pattern. This separates off-by-one errors at the four edges, blanking from background, and the two-clock timing of every result. The square style is run with a half period of three frames and then with a half period of zero. In these runs white against a non-white colour shows whether the "on" state passes the colour through unscaled. The sine style is run over enough frames to visit many table entries. The picture stream carries a pattern derived from the coordinates, which tells the picture source apart from the flat colour under both styles. A configuration change in the middle of a frame, and a rectangle that touches the largest column, check the shadow copy and the widened compare.

// File: rtl/stim_pkg.sv
package stim_pkg;

   typedef enum logic {
      FLK_SQUARE = 1'b0,
      FLK_SINE   = 1'b1
   } flk_style_e;

   // Sample idx of one sine period split into 2**aw steps, offset to mid-scale
   function automatic int sine_entry(int idx, int aw, int cw);
      real mid;
      real amp;
      real ang;
      mid = real'(2 ** (cw - 1));
      amp = mid - 1.0;
      ang = 2.0 * 3.14159265358979 * real'(idx) / real'(2 ** aw);
      return int'(mid + amp * $sin(ang));
   endfunction

endpackage

// File: rtl/stim_region.sv
module stim_region #(
   parameter int W = 11
) (
   input  logic [W-1:0] pos,
   input  logic [W-1:0] start,
   input  logic [W-1:0] size,
   output logic         hit
);
   logic [W:0] stop;

   always_comb begin
      stop = {1'b0, start} + {1'b0, size};
      hit  = (pos >= start) && ({1'b0, pos} < stop);
   end
endmodule

// File: rtl/stim_scale.sv
module stim_scale #(
   parameter int CW = 8
) (
   input  logic [CW-1:0] chan,
   input  logic [CW:0]   gray,
   output logic [CW-1:0] dimmed
);
   localparam int PW = 2 * CW + 1;
   logic [PW-1:0] prod;

   always_comb begin
      prod   = {{(CW + 1){1'b0}}, chan} * {{CW{1'b0}}, gray};
      dimmed = prod[2*CW-1:CW];
   end
endmodule

// File: rtl/stim_phase.sv
module stim_phase #(
   parameter int PHW = 16,
   parameter int AW  = 6,
   parameter int HFW = 8,
   parameter int CW  = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  frame_start,
   input  stim_pkg::flk_style_e  style,
   input  logic [HFW-1:0]        half_frames,
   input  logic [PHW-1:0]        step,
   output logic [CW:0]           gray,
   output logic [PHW-1:0]        phase_o,
   output logic                  sq_on_o
);
   localparam int TBL = 2 ** AW;

   logic [PHW-1:0] phase_q;
   logic [HFW-1:0] cnt_q;
   logic           sq_on_q;
   logic [HFW:0]   hf_eff;
   logic [CW-1:0]  rom [TBL];
   logic [AW-1:0]  idx;

   for (genvar g = 0; g < TBL; g++) begin : g_rom
      localparam int VAL = stim_pkg::sine_entry(g, AW, CW);
      assign rom[g] = VAL[CW-1:0];
   end

   always_comb begin
      hf_eff = (half_frames == '0) ? (HFW + 1)'(1) : {1'b0, half_frames};
      idx    = phase_q[PHW-1 -: AW];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= '0;
         cnt_q   <= '0;
         sq_on_q <= 1'b1;
      end else if (frame_start) begin
         phase_q <= phase_q + step;
         if (({1'b0, cnt_q} + 1'b1) >= hf_eff) begin
            cnt_q   <= '0;
            sq_on_q <= ~sq_on_q;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   always_comb begin
      if (style == stim_pkg::FLK_SINE)
         gray = {1'b0, rom[idx]};
      else
         gray = sq_on_q ? (CW + 1)'(1 << CW) : '0;
   end

   assign phase_o = phase_q;
   assign sq_on_o = sq_on_q;
endmodule

// File: rtl/stim_rect_overlay.sv
module stim_rect_overlay #(
   parameter int XW  = 11,
   parameter int YW  = 10,
   parameter int CW  = 8,
   parameter int PHW = 16,
   parameter int AW  = 6,
   parameter int HFW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              active,
   input  logic [XW-1:0]     pix_x,
   input  logic [YW-1:0]     pix_y,
   input  logic [3*CW-1:0]   pic_rgb,
   input  logic [XW-1:0]     cfg_x0,
   input  logic [YW-1:0]     cfg_y0,
   input  logic [XW-1:0]     cfg_w,
   input  logic [YW-1:0]     cfg_h,
   input  logic [3*CW-1:0]   cfg_color,
   input  logic [3*CW-1:0]   cfg_bg,
   input  logic              cfg_sine,
   input  logic              cfg_pic_en,
   input  logic [HFW-1:0]    cfg_half_frames,
   input  logic [PHW-1:0]    cfg_phase_step,
   output logic [3*CW-1:0]   out_rgb
);
   localparam int RGBW = 3 * CW;

   if (XW < 2 || YW < 2) begin : g_bad_xy
      $error("stim_rect_overlay: coordinate widths must be at least 2");
   end
   if (CW < 2 || CW > 12) begin : g_bad_cw
      $error("stim_rect_overlay: channel width out of range");
   end
   if (AW < 2 || AW > PHW) begin : g_bad_aw
      $error("stim_rect_overlay: table index wider than phase");
   end
   if (HFW < 1) begin : g_bad_hf
      $error("stim_rect_overlay: half-period counter needs a bit");
   end

   // shadow copies, refreshed only at frame start
   logic [XW-1:0]        sh_x0, sh_w;
   logic [YW-1:0]        sh_y0, sh_h;
   logic [RGBW-1:0]      sh_col, sh_bg;
   stim_pkg::flk_style_e sh_style;
   logic                 sh_pic;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_x0    <= '0;
         sh_w     <= '0;
         sh_y0    <= '0;
         sh_h     <= '0;
         sh_col   <= '0;
         sh_bg    <= '0;
         sh_style <= stim_pkg::FLK_SQUARE;
         sh_pic   <= 1'b0;
      end else if (frame_start) begin
         sh_x0    <= cfg_x0;
         sh_w     <= cfg_w;
         sh_y0    <= cfg_y0;
         sh_h     <= cfg_h;
         sh_col   <= cfg_color;
         sh_bg    <= cfg_bg;
         sh_style <= stim_pkg::flk_style_e'(cfg_sine);
         sh_pic   <= cfg_pic_en;
      end
   end

   logic [CW:0]    gray;
   logic [PHW-1:0] phase;
   logic           sq_on;

   stim_phase #(.PHW(PHW), .AW(AW), .HFW(HFW), .CW(CW)) u_phase (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .style       (sh_style),
      .half_frames (cfg_half_frames),
      .step        (cfg_phase_step),
      .gray        (gray),
      .phase_o     (phase),
      .sq_on_o     (sq_on)
   );

   logic hit_x, hit_y;

   stim_region #(.W(XW)) u_reg_x (.pos(pix_x), .start(sh_x0), .size(sh_w), .hit(hit_x));
   stim_region #(.W(YW)) u_reg_y (.pos(pix_y), .start(sh_y0), .size(sh_h), .hit(hit_y));

   // stage 1: region decision, source colour, gray level
   logic            s1_act, s1_in;
   logic [RGBW-1:0] s1_src;
   logic [CW:0]     s1_gray;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_act  <= 1'b0;
         s1_in   <= 1'b0;
         s1_src  <= '0;
         s1_gray <= '0;
      end else begin
         s1_act  <= active;
         s1_in   <= hit_x && hit_y;
         s1_src  <= sh_pic ? pic_rgb : sh_col;
         s1_gray <= gray;
      end
   end

   logic [RGBW-1:0] dimmed;

   for (genvar c = 0; c < 3; c++) begin : g_chan
      stim_scale #(.CW(CW)) u_scale (
         .chan   (s1_src[c*CW +: CW]),
         .gray   (s1_gray),
         .dimmed (dimmed[c*CW +: CW])
      );
   end

   // stage 2: output mux
   always_ff @(posedge clk) begin
      if (!rst_n)
         out_rgb <= '0;
      else if (!s1_act)
         out_rgb <= '0;
      else if (!s1_in)
         out_rgb <= sh_bg;
      else
         out_rgb <= dimmed;
   end
endmodule

// File: rtl/stim_rect_overlay_chk.sv
module stim_rect_overlay_chk #(
   parameter int XW   = 11,
   parameter int PHW  = 16,
   parameter int RGBW = 24
) (
   input logic            clk,
   input logic            rst_n,
   input logic            frame_start,
   input logic            active,
   input logic [RGBW-1:0] out_rgb,
   input logic [PHW-1:0]  phase,
   input logic            sq_on,
   input logic [XW-1:0]   sh_x0
);
   assert_reset_black_R1: assert property (@(posedge clk)
      !rst_n |=> (out_rgb == '0));

   assert_blank_black_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(active) |=> (out_rgb == '0));

   assert_square_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(sq_on));

   assert_phase_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(phase));

   assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(sh_x0));
endmodule

bind stim_rect_overlay stim_rect_overlay_chk #(
   .XW(XW), .PHW(PHW), .RGBW(3 * CW)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_start (frame_start),
   .active      (active),
   .out_rgb     (out_rgb),
   .phase       (phase),
   .sq_on       (sq_on),
   .sh_x0       (sh_x0)
);

// File: tb/stim_rect_overlay_bench.sv
module stim_rect_overlay_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_start = 1'b0;
   logic        active = 1'b0;
   logic [10:0] pix_x = '0;
   logic [9:0]  pix_y = '0;
   logic [23:0] pic_rgb = '0;
   logic [10:0] c_x0 = '0, c_w = '0;
   logic [9:0]  c_y0 = '0, c_h = '0;
   logic [23:0] c_col = '0, c_bg = '0;
   logic        c_sine = 1'b0, c_pic = 1'b0;
   logic [7:0]  c_half = 8'd1;
   logic [15:0] c_step = '0;
   logic [23:0] out_rgb;

   always #10 clk = ~clk;

   stim_rect_overlay u_stim_rect_overlay (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .active(active),
      .pix_x(pix_x), .pix_y(pix_y), .pic_rgb(pic_rgb),
      .cfg_x0(c_x0), .cfg_y0(c_y0), .cfg_w(c_w), .cfg_h(c_h),
      .cfg_color(c_col), .cfg_bg(c_bg), .cfg_sine(c_sine), .cfg_pic_en(c_pic),
      .cfg_half_frames(c_half), .cfg_phase_step(c_step), .out_rgb(out_rgb)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   // model state
   int m_x0 = 0, m_y0 = 0, m_w = 0, m_h = 0;
   logic [23:0] m_col = '0, m_bg = '0;
   bit m_sine = 0, m_pic = 0, m_on = 1;
   int m_cnt = 0, m_phase = 0;
   int tbl [64];

   // two-deep expectation pipeline
   logic [23:0] e1 = '0, e2 = '0;
   bit v1 = 0, v2 = 0;
   string t1 = "", t2 = "";

   function automatic logic [23:0] expect_pix(int x, int y, bit act, logic [23:0] pic);
      logic [23:0] src, res;
      int g;
      if (!act) return 24'h0;
      if (!(x >= m_x0 && x < m_x0 + m_w && y >= m_y0 && y < m_y0 + m_h)) return m_bg;
      src = m_pic ? pic : m_col;
      g = m_sine ? tbl[(m_phase >> 10) & 63] : (m_on ? 256 : 0);
      for (int c = 0; c < 3; c++) res[c*8 +: 8] = 8'((int'(src[c*8 +: 8]) * g) >> 8);
      return res;
   endfunction

   task automatic tick();
      @(negedge clk);
      if (v2) begin
         n_chk++;
         if (out_rgb !== e2) begin
            n_fail++;
            $display("FAIL %s: out_rgb=%06h expected=%06h", t2, out_rgb, e2);
         end
      end
   endtask

   task automatic push(logic [23:0] e, string t);
      e2 = e1; v2 = v1; t2 = t1;
      e1 = e;  v1 = 1;  t1 = t;
   endtask

   task automatic pix(int x, int y, bit act, logic [23:0] pic, string t);
      tick();
      frame_start = 1'b0;
      active = act;
      pix_x = 11'(x);
      pix_y = 10'(y);
      pic_rgb = pic;
      push(expect_pix(x, y, act, pic), t);
   endtask

   task automatic fs();
      int hf;
      tick();
      frame_start = 1'b1;
      active = 1'b0;
      push(24'h0, "R3");
      m_x0 = int'(c_x0); m_y0 = int'(c_y0); m_w = int'(c_w); m_h = int'(c_h);
      m_col = c_col; m_bg = c_bg; m_sine = c_sine; m_pic = c_pic;
      hf = (c_half == 0) ? 1 : int'(c_half);
      if (m_cnt + 1 >= hf) begin
         m_cnt = 0;
         m_on = !m_on;
      end else begin
         m_cnt++;
      end
      m_phase = (m_phase + int'(c_step)) & 16'hFFFF;
   endtask

   task automatic sweep(string t);
      int xa, xb, ya, yb;
      logic [23:0] pic;
      xa = (m_x0 - 2 < 0) ? 0 : m_x0 - 2;
      xb = (m_x0 + m_w + 1 > 2047) ? 2047 : m_x0 + m_w + 1;
      ya = (m_y0 - 2 < 0) ? 0 : m_y0 - 2;
      yb = (m_y0 + m_h + 1 > 1023) ? 1023 : m_y0 + m_h + 1;
      for (int y = ya; y <= yb; y++) begin
         for (int x = xa; x <= xb; x++) begin
            pic = {8'(x * 7), 8'(y * 13 + 5), 8'(x + y * 3)};
            pix(x, y, ((x * 3 + y) % 11) != 0, pic, t);
         end
      end
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run hung, actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 64; i++)
         tbl[i] = int'(128.0 + 127.0 * $sin(2.0 * 3.14159265358979 * real'(i) / 64.0));

      repeat (4) @(negedge clk);
      // R1: output black in reset even with an active pixel
      active = 1'b1;
      @(negedge clk);
      n_chk++;
      if (out_rgb !== 24'h0) begin
         n_fail++;
         $display("FAIL R1: out_rgb=%06h expected=000000", out_rgb);
      end
      active = 1'b0;
      rst_n = 1'b1;
      // R1: empty shadow rectangle, zero background after reset
      pix(0, 0, 1, 24'hABCDEF, "R1");
      pix(1, 1, 1, 24'h123456, "R1");

      // R2/R5 square style, half period 3, white
      c_x0 = 11'd5; c_y0 = 10'd3; c_w = 11'd6; c_h = 10'd4;
      c_col = 24'hFFFFFF; c_bg = 24'h102030; c_half = 8'd3;
      for (int f = 0; f < 7; f++) begin
         fs();
         sweep("R2 R4 R5");
      end

      // R5 half period 0 acts as 1, non-white colour passed unscaled
      c_col = 24'hC08040; c_half = 8'd0;
      for (int f = 0; f < 3; f++) begin
         fs();
         sweep("R5");
      end

      // R8 mid-frame configuration change has no effect until next frame
      fs();
      sweep("R8");
      c_x0 = 11'd7; c_w = 11'd3; c_col = 24'h00FF00; c_bg = 24'h777777;
      sweep("R8");
      fs();
      sweep("R8");

      // R6 sine style
      c_sine = 1'b1; c_step = 16'h0C40; c_col = 24'hFFFFFF; c_half = 8'd2;
      for (int f = 0; f < 12; f++) begin
         fs();
         sweep("R6");
      end

      // R7 picture source under sine then square
      c_pic = 1'b1;
      for (int f = 0; f < 4; f++) begin
         fs();
         sweep("R7");
      end
      c_sine = 1'b0;
      for (int f = 0; f < 3; f++) begin
         fs();
         sweep("R7");
      end

      // R2 rectangle touching the last column, no wrap of x0+w
      c_pic = 1'b0; c_x0 = 11'd2040; c_w = 11'd20; c_y0 = 10'd0; c_h = 10'd2;
      for (int f = 0; f < 2; f++) begin
         fs();
         sweep("R2");
      end

      // R9 flush: each result checked exactly two clocks after its input
      pix(0, 0, 0, 24'h0, "R9");
      pix(0, 0, 0, 24'h0, "R9");
      tick();

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule